// File: doc/BRIEF.md
# Bus Tenure Throttle

This unit paces a DMA mover's use of a shared bus. While a transfer is running it enables the mover's bus request. It adds up the bytes the mover reports during one ownership tenure. When the total reaches the programmed tenure length, it withdraws the request. It then holds the mover paused for a programmed back-off time, measured in microsecond ticks, before it enables the request again. When the transfer ends, the unit goes straight back to idle. No back-off is run in that case.

The tenure length and the back-off time come from two small power-of-two encoded fields of a control word. A separate combinational encoder turns a requested burst size in bytes into the tenure code that software would program. It rounds up to the next supported size. Arbitration and the data path lie outside this block.

Top module: `tenure_throttle`

## Requirements
- R1: While rst_ni is low, and after it is released until a transfer starts, bus_req_en_o and pause_o are both 0.
- R2: When xfer_active_i is sampled high in idle, bus_req_en_o is 1 from the next cycle on. Each tenure starts from a byte total of zero. byte_inc_i is not counted while idle or paused.
- R3: The tenure code sits in control bits 22:20. A code c from 1 to 7 gives a limit of 256·2^(c-1) bytes. byte_inc_i is added at every clock edge in a tenure. The request drops after the edge at which the total reaches or passes the limit. With a constant increment K, the request is therefore high for ceil(limit/K) cycles.
- R4: Tenure code 0 means no limit: the request stays high for as long as the transfer runs.
- R5: The back-off code sits in control bits 19:16. Code 0 gives a one-cycle pause. A code w from 1 to 7 waits 16·2^(w-1) microsecond ticks. Codes 8 to 15 wait 1024 ticks.
- R6: pause_o is high exactly while backing off, and it is never high together with bus_req_en_o. The wait advances only on us_tick_i pulses. The request returns in the cycle after the tick that completes the wait.
- R7: When xfer_active_i is sampled low, both outputs are 0 in the next cycle, whether the unit was in a tenure or in a back-off. A later transfer starts a fresh tenure.
- R8: burst_code_o gives, combinationally, the smallest code from 1 to 7 whose size is at least burst_req_i. Any value above 16384 gives code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | 32 | Control word; tenure code in 22:20, back-off code in 19:16 |
| xfer_active_i | input | 1 | High while the mover has a transfer to run |
| byte_inc_i | input | 8 | Bytes moved by the mover in this cycle |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| burst_req_i | input | 16 | Requested burst size in bytes, for encoding |
| bus_req_en_o | output | 1 | Enable for the mover's bus request |
| pause_o | output | 1 | Mover must hold off (back-off in progress) |
| burst_code_o | output | 3 | Tenure code encoded from burst_req_i |

## Verification
bus_req_en_o and pause_o come from registers. Each changes one cycle after the clock edge that samples its cause: the transfer flag, the byte total that reaches the limit, or the tick that completes the wait. burst_code_o settles within the same cycle as burst_req_i. The bench drives every input on the falling edge and reads the outputs on a later falling edge, so each registered result is read one cycle after its cause. Tenure and pause lengths are obtained by counting consecutive samples and are compared with ceil(limit/K) and with max(1, wait). The encoder is compared a short delay after each new request value, with no clock involved.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TENURE  = 2'd1,
    ST_BACKOFF = 2'd2
  } thr_state_e;
endpackage

// File: rtl/tt_field_decode.sv
module tt_field_decode #(
  parameter int CTRL_W        = 32,
  parameter int TEN_LSB       = 20,
  parameter int OFF_LSB       = 16,
  parameter int TEN_BASE_LOG2 = 8,
  parameter int OFF_BASE_LOG2 = 4,
  parameter int LIM_W         = 16,
  parameter int WAIT_W        = 11
) (
  input  logic [CTRL_W-1:0] ctrl_word_i,
  output logic [LIM_W-1:0]  limit_o,
  output logic              unlimited_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [2:0] ten_code;
  logic [3:0] off_code;
  logic [2:0] off_eff;

  assign ten_code    = ctrl_word_i[TEN_LSB +: 3];
  assign off_code    = ctrl_word_i[OFF_LSB +: 4];
  assign unlimited_o = (ten_code == 3'd0);
  // codes above 7 saturate to the longest wait
  assign off_eff     = off_code[3] ? 3'd7 : off_code[2:0];

  always_comb begin
    limit_o = '0;
    if (!unlimited_o) limit_o = LIM_W'(1) << (TEN_BASE_LOG2 - 1 + 32'(ten_code));
    wait_o = '0;
    if (off_eff != 3'd0) wait_o = WAIT_W'(1) << (OFF_BASE_LOG2 - 1 + 32'(off_eff));
  end
endmodule

// File: rtl/tt_burst_encode.sv
module tt_burst_encode #(
  parameter int REQ_W         = 16,
  parameter int TEN_BASE_LOG2 = 8
) (
  input  logic [REQ_W-1:0] burst_req_i,
  output logic [2:0]       burst_code_o
);
  always_comb begin
    burst_code_o = 3'd7;
    // descending scan, so the smallest fitting size wins
    for (int c = 7; c >= 1; c--) begin
      if (33'(burst_req_i) <= (33'd1 << (TEN_BASE_LOG2 - 1 + c)))
        burst_code_o = 3'(c);
    end
  end
endmodule

// File: rtl/tt_backoff_timer.sv
module tt_backoff_timer #(
  parameter int WAIT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              expire_o
);
  logic [WAIT_W-1:0] tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_cnt <= '0;
    else if (!run_i)  tick_cnt <= '0;
    else if (tick_i)  tick_cnt <= tick_cnt + 1'b1;
  end

  assign expire_o = (wait_i == '0) ||
                    (tick_i && (({1'b0, tick_cnt} + 1'b1) >= {1'b0, wait_i}));
endmodule

// File: rtl/tenure_throttle.sv
module tenure_throttle
  import throttle_pkg::*;
#(
  parameter int CTRL_W        = 32,
  parameter int TEN_LSB       = 20,
  parameter int OFF_LSB       = 16,
  parameter int TEN_BASE_LOG2 = 8,
  parameter int OFF_BASE_LOG2 = 4,
  parameter int INC_W         = 8,
  parameter int REQ_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              xfer_active_i,
  input  logic [INC_W-1:0]  byte_inc_i,
  input  logic              us_tick_i,
  input  logic [REQ_W-1:0]  burst_req_i,
  output logic              bus_req_en_o,
  output logic              pause_o,
  output logic [2:0]        burst_code_o
);
  localparam int LIM_W  = TEN_BASE_LOG2 + 8;
  localparam int WAIT_W = OFF_BASE_LOG2 + 7;
  localparam int SUM_W  = LIM_W + 1;

  thr_state_e        state_q, state_d;
  logic [LIM_W-1:0]  byte_cnt;
  logic [SUM_W-1:0]  byte_sum;
  logic [LIM_W-1:0]  limit;
  logic              unlimited;
  logic [WAIT_W-1:0] wait_us;
  logic              expire;

  tt_field_decode #(
    .CTRL_W(CTRL_W), .TEN_LSB(TEN_LSB), .OFF_LSB(OFF_LSB),
    .TEN_BASE_LOG2(TEN_BASE_LOG2), .OFF_BASE_LOG2(OFF_BASE_LOG2),
    .LIM_W(LIM_W), .WAIT_W(WAIT_W)
  ) dec_i (
    .ctrl_word_i(ctrl_word_i), .limit_o(limit),
    .unlimited_o(unlimited), .wait_o(wait_us)
  );

  tt_backoff_timer #(.WAIT_W(WAIT_W)) tmr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_BACKOFF),
    .tick_i(us_tick_i), .wait_i(wait_us), .expire_o(expire)
  );

  tt_burst_encode #(.REQ_W(REQ_W), .TEN_BASE_LOG2(TEN_BASE_LOG2)) enc_i (
    .burst_req_i(burst_req_i), .burst_code_o(burst_code_o)
  );

  assign byte_sum = {1'b0, byte_cnt} + SUM_W'(byte_inc_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (xfer_active_i) state_d = ST_TENURE;
      ST_TENURE: begin
        if (!xfer_active_i)                                state_d = ST_IDLE;
        else if (!unlimited && byte_sum >= SUM_W'(limit))  state_d = ST_BACKOFF;
      end
      ST_BACKOFF: begin
        if (!xfer_active_i) state_d = ST_IDLE;
        else if (expire)    state_d = ST_TENURE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      byte_cnt <= '0;
    end else begin
      state_q  <= state_d;
      // total only carries within one tenure
      byte_cnt <= (state_q == ST_TENURE && state_d == ST_TENURE) ? byte_sum[LIM_W-1:0] : '0;
    end
  end

  assign bus_req_en_o = (state_q == ST_TENURE);
  assign pause_o      = (state_q == ST_BACKOFF);
endmodule

// File: rtl/tenure_throttle_chk.sv
module tenure_throttle_chk #(
  parameter int CTRL_W        = 32,
  parameter int TEN_LSB       = 20,
  parameter int OFF_LSB       = 16,
  parameter int TEN_BASE_LOG2 = 8,
  parameter int REQ_W         = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_word_i,
  input logic              xfer_active_i,
  input logic              us_tick_i,
  input logic [REQ_W-1:0]  burst_req_i,
  input logic              bus_req_en_o,
  input logic              pause_o,
  input logic [2:0]        burst_code_o
);
  localparam int MAX_BURST = 1 << (TEN_BASE_LOG2 + 6);

  AST_REQ_PAUSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_en_o && pause_o)); // R6
  AST_END_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_active_i |=> (!bus_req_en_o && !pause_o)); // R7
  AST_PAUSE_AFTER_TENURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_o) |-> $past(bus_req_en_o)); // R3
  AST_WAIT_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && xfer_active_i && !us_tick_i && ctrl_word_i[OFF_LSB +: 4] != 4'd0)
      |=> pause_o); // R6
  AST_UNLIMITED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_en_o && xfer_active_i && ctrl_word_i[TEN_LSB +: 3] == 3'd0)
      |=> bus_req_en_o); // R4
  AST_ENC_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(burst_req_i) > MAX_BURST) |-> (burst_code_o == 3'd7)); // R8
  AST_ENC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_code_o != 3'd0); // R8
endmodule

bind tenure_throttle tenure_throttle_chk #(
  .CTRL_W(CTRL_W), .TEN_LSB(TEN_LSB), .OFF_LSB(OFF_LSB),
  .TEN_BASE_LOG2(TEN_BASE_LOG2), .REQ_W(REQ_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_word_i(ctrl_word_i),
  .xfer_active_i(xfer_active_i), .us_tick_i(us_tick_i),
  .burst_req_i(burst_req_i), .bus_req_en_o(bus_req_en_o),
  .pause_o(pause_o), .burst_code_o(burst_code_o)
);

// File: tb/tenure_throttle_tb_top.sv
`timescale 1ns/1ps
module tenure_throttle_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_word_i = '0;
  logic        xfer_active_i = 1'b0;
  logic [7:0]  byte_inc_i = '0;
  logic        us_tick_i = 1'b0;
  logic [15:0] burst_req_i = '0;
  logic        bus_req_en_o, pause_o;
  logic [2:0]  burst_code_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tenure_throttle dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_word_i(ctrl_word_i),
    .xfer_active_i(xfer_active_i), .byte_inc_i(byte_inc_i),
    .us_tick_i(us_tick_i), .burst_req_i(burst_req_i),
    .bus_req_en_o(bus_req_en_o), .pause_o(pause_o), .burst_code_o(burst_code_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ten_bytes(input int c);
    return 256 * (1 << (c - 1));
  endfunction

  function automatic int wait_ticks(input int w);
    if (w == 0) return 0;
    if (w >= 8) return 1024;
    return 16 * (1 << (w - 1));
  endfunction

  function automatic int ctrl(input int t, input int o);
    return (t << 20) | (o << 16);
  endfunction

  // count consecutive samples with request high, then with pause high
  task automatic measure(output int hi, output int pz);
    @(negedge clk_i);
    hi = 0;
    while (bus_req_en_o && hi < 40000) begin hi++; @(negedge clk_i); end
    pz = 0;
    while (pause_o && pz < 5000) begin pz++; @(negedge clk_i); end
  endtask

  task automatic stop_xfer();
    xfer_active_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi, pz, exp_c;
    int ks[3] = '{64, 100, 255};
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(int'(bus_req_en_o), 0, "R1 req in reset");
    chk(int'(pause_o), 0, "R1 pause in reset");
    rst_ni = 1'b1;
    byte_inc_i = 8'd200;
    repeat (3) @(negedge clk_i);
    chk(int'(bus_req_en_o) + int'(pause_o), 0, "R1 idle after reset");

    // R3 R2 tenure sweep, zero back-off (R5 one-cycle pause)
    us_tick_i = 1'b1;
    for (int c = 1; c <= 7; c++) begin
      foreach (ks[k]) begin
        ctrl_word_i = 32'(ctrl(c, 0));
        byte_inc_i = 8'(ks[k]);
        xfer_active_i = 1'b1;
        measure(hi, pz);
        chk(hi, (ten_bytes(c) + ks[k] - 1) / ks[k], $sformatf("R3 tenure c=%0d k=%0d", c, ks[k]));
        chk(pz, 1, "R5 code0 pause");
        chk(int'(bus_req_en_o), 1, "R6 request back");
        stop_xfer();
        chk(int'(bus_req_en_o) + int'(pause_o), 0, "R7 idle after end");
      end
    end

    // R5 back-off sweep with a tick every cycle
    for (int w = 0; w < 16; w++) begin
      ctrl_word_i = 32'(ctrl(1, w));
      byte_inc_i = 8'd255;
      xfer_active_i = 1'b1;
      measure(hi, pz);
      chk(hi, 2, "R3 tenure before back-off");
      exp_c = (wait_ticks(w) == 0) ? 1 : wait_ticks(w);
      chk(pz, exp_c, $sformatf("R5 back-off w=%0d", w));
      chk(int'(bus_req_en_o), 1, "R6 request after wait");
      stop_xfer();
    end

    // R4 unlimited tenure
    ctrl_word_i = 32'(ctrl(0, 3));
    byte_inc_i = 8'd255;
    xfer_active_i = 1'b1;
    hi = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      if (bus_req_en_o && !pause_o) hi++;
    end
    chk(hi, 500, "R4 unlimited request held");
    xfer_active_i = 1'b0;
    @(negedge clk_i);
    chk(int'(bus_req_en_o), 0, "R7 end during tenure");
    @(negedge clk_i);

    // R6 wait advances only on ticks; R2 bytes ignored while paused
    us_tick_i = 1'b0;
    ctrl_word_i = 32'(ctrl(1, 1));
    byte_inc_i = 8'd128;
    xfer_active_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(int'(pause_o), 1, "R6 paused");
    repeat (100) @(negedge clk_i);
    chk(int'(pause_o), 1, "R6 pause held without ticks");
    chk(int'(bus_req_en_o), 0, "R6 no request while paused");
    byte_inc_i = 8'd1;
    us_tick_i = 1'b1;
    pz = 0;
    while (pause_o && pz < 100) begin pz++; @(negedge clk_i); end
    chk(pz, 16, "R6 pause after ticks resume");
    hi = 0;
    while (bus_req_en_o && hi < 1000) begin hi++; @(negedge clk_i); end
    chk(hi, 256, "R2 fresh tenure after pause");
    stop_xfer();

    // R7 end during back-off, then fresh start
    ctrl_word_i = 32'(ctrl(1, 7));
    byte_inc_i = 8'd255;
    xfer_active_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(int'(pause_o), 1, "R7 in back-off");
    xfer_active_i = 1'b0;
    @(negedge clk_i);
    chk(int'(pause_o) + int'(bus_req_en_o), 0, "R7 end during back-off");
    ctrl_word_i = 32'(ctrl(1, 0));
    byte_inc_i = 8'd100;
    xfer_active_i = 1'b1;
    measure(hi, pz);
    chk(hi, 3, "R7 restart fresh tenure");
    stop_xfer();

    // R8 encoder full sweep
    for (int r = 0; r < 65536; r++) begin
      burst_req_i = 16'(r);
      #1;
      if (r <= 256) exp_c = 1;
      else begin
        exp_c = $clog2(r) - 7;
        if (exp_c > 7) exp_c = 7;
      end
      if (int'(burst_code_o) != exp_c) chk(int'(burst_code_o), exp_c, $sformatf("R8 encode %0d", r));
      else n_run++;
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule